// File: doc/BRIEF.md
# Asymmetric Regular-Sampled Sine PWM Generator

This block drives a complementary pulse pair whose duty follows a sine wave. A triangular carrier counter rises from zero to a parameter value `PERIOD` and falls back to zero, one step per clock. Each time the counter reaches either end, the block takes one sample of a sine table. It scales that sample by an 8-bit modulation index and stores the result as the next compare threshold. The threshold is double-buffered. Because both carrier ends take a sample, the rising half and the falling half of each carrier cycle use different thresholds, and the pulse is asymmetric.

The sine table holds `2*RATIO` signed 16-bit points covering one full reference cycle, where `RATIO` is the number of carrier periods per reference period. Peak events step through the even table addresses and zero events step through the odd ones. A low enable freezes the carrier, forces both outputs low and rewinds the table pointers.

Top module: `spwm_gen`

## Requirements
- R1: The carrier counter starts at 0 after reset and moves by one per enabled clock, up to `PERIOD` and back down to 0, so one carrier cycle lasts `2*PERIOD` clocks. The value 0 is a zero event and `PERIOD` is a peak event.
- R2: In the cycle after the counter equals the active threshold while rising, `pwm_a` goes low. In the cycle after it equals the active threshold while falling, `pwm_a` goes high. Otherwise `pwm_a` holds its value. The value 0 is taken as rising after reset and falling at the bottom turn, and `PERIOD` is taken as rising.
- R3: While enabled, `pwm_b` is always the inverse of `pwm_a`.
- R4: At every zero or peak event, the active threshold is loaded from the shadow threshold. Until that load, the old active value stays in use for the whole cycle of the event.
- R5: At each event the new shadow threshold is H + ((s*m*H + 2^22) >>> 23), where H = PERIOD/2, m is `mod_idx` as unsigned, >>> is an arithmetic shift, and s = round(32767*sin(k*pi/RATIO)) is the table entry at address k. The result always lies in 0..PERIOD, and it is ready well before the next event.
- R6: Peak events use even addresses starting at 0, and zero events use odd addresses starting at 1. Each pointer advances by 2 after use. The even pointer returns to 0 when its next value would exceed 2*RATIO-2, and the odd pointer returns to 1 when its next value would exceed 2*RATIO-1.
- R7: `smp_evt` is a one-clock pulse in the cycle after each event, and `smp_peak` is 1 with it for peak events and 0 for zero events.
- R8: After synchronous reset, the counter is 0 and rising, both thresholds equal PERIOD/2, `pwm_a` is 1, `pwm_b` is 0 and `smp_evt` is 0.
- R9: While `en` is low, the counter and thresholds hold, no event fires, the pointers return to 0 and 1, and both outputs are 0 from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable |
| mod_idx | input | 8 | Modulation index, unsigned fraction of 256 |
| pwm_a | output | 1 | Main PWM output |
| pwm_b | output | 1 | Complementary PWM output |
| smp_evt | output | 1 | Sample event pulse |
| smp_peak | output | 1 | Event came from the carrier peak |

## Verification
A wrong carrier count or turn point shows up within one carrier half-period: the `smp_evt` pulses are no longer `PERIOD` clocks apart, or `smp_peak` stops alternating. A wrong pointer, table entry or scale factor moves a `pwm_a` edge at the next compare match after the affected threshold becomes active, which is at most one carrier cycle later. A shadow or active threshold that loads from the wrong event shifts the edge of the rising half-cycle against the falling one. The bench compares every output on every clock against a model built from the requirements, so any of these faults is reported in the cycle where it first reaches a pin.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  // Next table pointer: advance by two, fold back to base past the limit.
  function automatic int next_idx(input int k, input int limit, input int base);
    if (k + 2 > limit) return base;
    return k + 2;
  endfunction
endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int PERIOD = 1500,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic [CW-1:0] cnt,
  output logic          up,
  output logic          zero_hit,
  output logic          peak_hit
);
  localparam logic [CW-1:0] TOP = CW'(PERIOD);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (en) begin
      if (up) begin
        if (cnt == TOP) begin
          up  <= 1'b0;
          cnt <= TOP - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        if (cnt == '0) begin
          up  <= 1'b1;
          cnt <= CW'(1);
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign zero_hit = en && (cnt == '0);
  assign peak_hit = en && (cnt == TOP);

  a_r1_bound: assert property (@(posedge clk) disable iff (rst) cnt <= TOP);
  a_r1_rise: assert property (@(posedge clk) disable iff (rst)
    (en && up && cnt != TOP) |=> cnt == $past(cnt) + 1'b1);
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt) && $stable(up));
endmodule

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
  parameter int RATIO = 400,
  parameter int S_W   = 16,
  localparam int DEPTH = 2 * RATIO,
  localparam int KW    = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic [KW-1:0]         addr,
  output logic signed [S_W-1:0] data
);
  logic signed [S_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      real ang, v;
      ang = 3.14159265358979 * i / RATIO;
      v   = ((2.0 ** (S_W - 1)) - 1.0) * $sin(ang);
      mem[i] = S_W'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
    end
  end

  always_ff @(posedge clk) begin
    data <= mem[addr];
  end
endmodule

// File: rtl/spwm_modulator.sv
module spwm_modulator #(
  parameter int PERIOD = 1500,
  parameter int RATIO  = 400,
  parameter int M_W    = 8,
  parameter int S_W    = 16,
  localparam int CW    = $clog2(PERIOD + 1),
  localparam int KW    = $clog2(2 * RATIO)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           zero_hit,
  input  logic           peak_hit,
  input  logic [M_W-1:0] mod_idx,
  output logic [CW-1:0]  active
);
  localparam int HALF = PERIOD / 2;
  localparam int SH   = S_W - 1 + M_W;
  localparam int XW   = S_W + M_W + CW + 3;

  logic [KW-1:0]         k_even, k_odd, addr_q;
  logic [M_W-1:0]        m_q;
  logic                  v1, v2;
  logic signed [S_W-1:0] rom_q;
  logic [CW-1:0]         shadow;
  logic signed [XW-1:0]  scaled, rounded, total;

  spwm_sine_rom #(.RATIO(RATIO), .S_W(S_W)) u_rom (
    .clk(clk), .addr(addr_q), .data(rom_q)
  );

  always_comb begin
    scaled  = XW'(rom_q) * XW'($signed({1'b0, m_q})) * XW'(HALF);
    rounded = (scaled + (XW'(1) <<< (SH - 1))) >>> SH;
    total   = rounded + XW'(HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_even <= '0;
      k_odd  <= KW'(1);
      addr_q <= '0;
      m_q    <= '0;
      v1     <= 1'b0;
      v2     <= 1'b0;
      shadow <= CW'(HALF);
      active <= CW'(HALF);
    end else begin
      v1 <= zero_hit || peak_hit;
      v2 <= v1;
      if (zero_hit || peak_hit) begin
        active <= shadow;
        m_q    <= mod_idx;
        addr_q <= peak_hit ? k_even : k_odd;
      end
      if (!en) begin
        k_even <= '0;
        k_odd  <= KW'(1);
      end else if (peak_hit) begin
        k_even <= KW'(spwm_pkg::next_idx(int'(k_even), 2 * RATIO - 2, 0));
      end else if (zero_hit) begin
        k_odd <= KW'(spwm_pkg::next_idx(int'(k_odd), 2 * RATIO - 1, 1));
      end
      if (v2) shadow <= total[CW-1:0];
    end
  end

  a_r5_shadow_range: assert property (@(posedge clk) disable iff (rst)
    shadow <= CW'(PERIOD));
  a_r6_parity: assert property (@(posedge clk) disable iff (rst)
    !k_even[0] && k_odd[0]);
  a_r4_load: assert property (@(posedge clk) disable iff (rst)
    (zero_hit || peak_hit) |=> active == $past(shadow));
  a_r4_keep: assert property (@(posedge clk) disable iff (rst)
    !(zero_hit || peak_hit) |=> $stable(active));
endmodule

// File: rtl/spwm_gen.sv
module spwm_gen #(
  parameter int PERIOD = 1500,
  parameter int RATIO  = 400,
  parameter int M_W    = 8,
  parameter int S_W    = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [M_W-1:0] mod_idx,
  output logic           pwm_a,
  output logic           pwm_b,
  output logic           smp_evt,
  output logic           smp_peak
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt, active;
  logic          up, zero_hit, peak_hit;
  logic          a_st, a_nxt;

  spwm_carrier #(.PERIOD(PERIOD)) u_car (
    .clk(clk), .rst(rst), .en(en),
    .cnt(cnt), .up(up), .zero_hit(zero_hit), .peak_hit(peak_hit)
  );

  spwm_modulator #(.PERIOD(PERIOD), .RATIO(RATIO), .M_W(M_W), .S_W(S_W)) u_mod (
    .clk(clk), .rst(rst), .en(en),
    .zero_hit(zero_hit), .peak_hit(peak_hit),
    .mod_idx(mod_idx), .active(active)
  );

  always_comb begin
    a_nxt = a_st;
    if (cnt == active) a_nxt = !up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_st     <= 1'b1;
      pwm_a    <= 1'b1;
      pwm_b    <= 1'b0;
      smp_evt  <= 1'b0;
      smp_peak <= 1'b0;
    end else begin
      if (en) a_st <= a_nxt;
      pwm_a    <= en && a_nxt;
      pwm_b    <= en && !a_nxt;
      smp_evt  <= zero_hit || peak_hit;
      smp_peak <= peak_hit;
    end
  end

  a_r3_exclusive: assert property (@(posedge clk) disable iff (rst) !(pwm_a && pwm_b));
  a_r9_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> !pwm_a && !pwm_b);
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst) smp_evt |=> !smp_evt);
  a_r7_flag: assert property (@(posedge clk) disable iff (rst) smp_peak |-> smp_evt);
endmodule

// File: tb/spwm_gen_bench.sv
module spwm_gen_bench;
  localparam int P  = 20;
  localparam int NR = 8;
  localparam int H  = P / 2;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [7:0] mod_idx = 8'd0;
  logic pwm_a, pwm_b, smp_evt, smp_peak;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  spwm_gen #(.PERIOD(P), .RATIO(NR)) u_spwm_gen (
    .clk(clk), .rst(rst), .en(en), .mod_idx(mod_idx),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .smp_evt(smp_evt), .smp_peak(smp_peak)
  );

  // Threshold from the R5 formula, computed independently of the design.
  function automatic int thr(input int k, input int m);
    real v;
    longint s, x;
    v = 32767.0 * $sin(3.14159265358979 * k / NR);
    s = longint'($rtoi(v >= 0.0 ? v + 0.5 : v - 0.5));
    x = (s * m * H + 64'sd4194304) >>> 23;
    return H + int'(x);
  endfunction

  // Reference model of R1..R9, stepped on the clock edge.
  int  c, act, sh, ke, ko;
  bit  upm, ast, ea, eb, ee, ep;
  always @(posedge clk) begin
    bit zh, ph, an;
    if (rst) begin
      c = 0; upm = 1; act = H; sh = H; ke = 0; ko = 1; ast = 1;
      ea = 1; eb = 0; ee = 0; ep = 0;
    end else begin
      zh = en && c == 0;
      ph = en && c == P;
      an = ast;
      if (c == act) an = !upm;
      ea = en && an; eb = en && !an; ee = zh || ph; ep = ph;
      if (en) ast = an;
      if (zh || ph) begin
        act = sh;
        sh  = thr(ph ? ke : ko, int'(mod_idx));
        if (ph) ke = (ke + 2 > 2*NR-2) ? 0 : ke + 2;
        else    ko = (ko + 2 > 2*NR-1) ? 1 : ko + 2;
      end
      if (!en) begin ke = 0; ko = 1; end
      if (en) begin
        if (upm) begin
          if (c == P) begin upm = 0; c = P - 1; end else c = c + 1;
        end else begin
          if (c == 0) begin upm = 1; c = 1; end else c = c - 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act_v, input int exp_v);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act_v, exp_v, $time);
    end
  endtask

  task automatic cmp_all();
    chk(pwm_a == ea, "R2/R4/R5/R6 pwm_a", int'(pwm_a), int'(ea));
    chk(pwm_b == eb, "R3 pwm_b", int'(pwm_b), int'(eb));
    chk(smp_evt == ee, "R1/R7 smp_evt", int'(smp_evt), int'(ee));
    chk(smp_peak == ep, "R7 smp_peak", int'(smp_peak), int'(ep));
  endtask

  typedef struct packed {
    logic [7:0]  m;
    logic        e;
    logic [15:0] cyc;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{8'd204, 1'b1, 16'd700},
    '{8'd255, 1'b1, 16'd400},
    '{8'd0,   1'b1, 16'd200},
    '{8'd128, 1'b0, 16'd30},
    '{8'd128, 1'b1, 16'd400},
    '{8'd64,  1'b1, 16'd53},
    '{8'd64,  1'b0, 16'd5},
    '{8'd255, 1'b1, 16'd400}
  };

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset values at the pins
    chk(pwm_a == 1'b1, "R8 pwm_a", int'(pwm_a), 1);
    chk(pwm_b == 1'b0, "R8 pwm_b", int'(pwm_b), 0);
    chk(smp_evt == 1'b0, "R8 smp_evt", int'(smp_evt), 0);
    rst = 1'b0;
    foreach (VEC[i]) begin
      mod_idx = VEC[i].m;
      en      = VEC[i].e;
      for (int j = 0; j < int'(VEC[i].cyc); j++) begin
        @(negedge clk);
        cmp_all();
      end
    end
    // R9: disabled outputs stay low and no events
    en = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      chk(!pwm_a && !pwm_b, "R9 outputs low", int'({pwm_a, pwm_b}), 0);
      chk(!smp_evt, "R9 no event", int'(smp_evt), 0);
    end
    // R8: reset in mid-run returns to the reset state
    en = 1'b1;
    repeat (37) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(pwm_a == 1'b1 && pwm_b == 1'b0, "R8 mid-run reset", int'({pwm_a, pwm_b}), 2);
    rst = 1'b0;
    // R1/R7: first event is a zero event right after reset, then the peak P clocks later
    @(negedge clk);
    chk(smp_evt && !smp_peak, "R7 first zero event", int'({smp_evt, smp_peak}), 2);
    repeat (P - 1) @(negedge clk);
    chk(!smp_evt, "R1 no event before peak", int'(smp_evt), 0);
    @(negedge clk);
    chk(smp_evt && smp_peak, "R1 peak event spacing", int'({smp_evt, smp_peak}), 3);
    for (int j = 0; j < 300; j++) begin
      @(negedge clk);
      cmp_all();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule